// File: doc/BRIEF.md
# Distributor Routing-Mode Control Register

This block is the control word of an interrupt distributor. It stores three interrupt-group enables and two affinity-routing enables, one for the secure state and one for the non-secure state. It also stores a bit that turns the security split off, and it reports a write-in-progress flag. Software writes the whole word in one access. The block checks every write that would change a routing enable against the enables that are stored when the write arrives. It refuses an illegal change to a routing bit and raises a one-cycle error pulse.

After each write, the write-in-progress flag is held high for a fixed number of commit cycles. Software polls this flag, and once it reads 0 the new configuration is in force. The logic that uses these bits, the bus bridge and the other distributor registers sit outside this block.

Top module: `irq_route_ctrl`

## Requirements
- R1: Reset sets every stored field, the flag and the error output to 0. The read word has a fixed layout: bit 0 is group 0 enable, bit 1 is group 1 enable (secure group 1 when the split is on, combined group 1 when it is off), bit 2 is non-secure group 1 enable, bit 4 is secure routing enable, bit 5 is non-secure routing enable, bit 6 is security-off and bit 31 is write-pending. All other bits read 0.
- R2: A write that would take a routing bit from 1 to 0 is illegal. The bit keeps its value of 1.
- R3: A write that would take a routing bit from 0 to 1 is legal only if every checked group enable is 0. The check uses the stored values from before the write, not the written ones.
- R4: With security-off at 0, the checked enables are bits 0, 1 and 2.
- R5: With security-off at 1, the checked enables are bit 0 and bit 1 only. Bit 2 is still stored and read back, but it does not block a routing change.
- R6: An illegal write still updates the group enables and security-off. `err_o` is 1 in exactly the one cycle after the write and 0 in the cycle after that.
- R7: The write-pending bit rises in the cycle after any write and stays 1 for exactly COMMIT_CYC cycles (default 4). A new write restarts the count.
- R8: Legal routing writes take effect. These include setting a routing bit while the checked groups are off, and writing a routing bit with the value it already holds, whatever the group enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | DATA_W | Data to write |
| rd_data | output | DATA_W | Current contents of the control word |
| err_o | output | 1 | One-cycle pulse for an illegal routing change |

## Verification
A write is captured on one rising edge. The stored fields, `err_o` and the first high cycle of write-pending are all visible from the following cycle, so the bench samples them at the falling edge just after the write. `err_o` is checked once more one cycle later and must be 0 there. Write-pending is polled at successive falling edges, and the number of high samples must equal COMMIT_CYC, both after a single write and after a second write that arrives during the commit window. The legality sweep covers both security modes, all eight group patterns, and every combination of current and requested routing bits. For each case the bench computes the expected word and error from the rules.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int F_G0   = 0;
  localparam int F_G1A  = 1;
  localparam int F_G1B  = 2;
  localparam int F_RSEC = 4;
  localparam int F_RNS  = 5;
  localparam int F_SOFF = 6;
  localparam int F_PEND = 31;
  localparam int N_GRP   = 3;
  localparam int N_ROUTE = 2;

  typedef struct packed {
    logic               soff;
    logic [N_ROUTE-1:0] route;  // [0] secure, [1] non-secure
    logic [N_GRP-1:0]   grp;    // [0] g0, [1] g1 (secure or combined), [2] g1 non-secure
  } ctl_t;

  // Whether any enable that gates a routing change is set.
  function automatic logic groups_busy(input logic soff, input logic [N_GRP-1:0] grp);
    if (soff) return grp[0] | grp[1];
    return |grp;
  endfunction

  // Illegal when clearing, or when setting while any gating group is enabled.
  function automatic logic route_illegal(input logic cur, input logic req, input logic busy);
    return (cur & ~req) | (~cur & req & busy);
  endfunction

endpackage

// File: rtl/irq_route_legal.sv
module irq_route_legal
  import irq_route_pkg::*;
#(
  parameter int N = N_ROUTE
) (
  input  logic [N-1:0] cur,
  input  logic [N-1:0] req,
  input  logic         busy,
  output logic [N-1:0] nxt,
  output logic [N-1:0] bad
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      bad[i] = route_illegal(cur[i], req[i], busy);
      nxt[i] = bad[i] ? cur[i] : req[i];
    end
  end
endmodule

// File: rtl/irq_route_commit.sv
module irq_route_commit #(
  parameter int COMMIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pending
);
  localparam int CW = $clog2(COMMIT_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(COMMIT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pending = (cnt_q != '0);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COMMIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_o
);
  ctl_t ctl_q;
  ctl_t req;
  logic grp_busy;
  logic [N_ROUTE-1:0] route_nxt;
  logic [N_ROUTE-1:0] route_bad;
  logic pending;
  logic err_q;

  always_comb begin
    req.grp   = {wr_data[F_G1B], wr_data[F_G1A], wr_data[F_G0]};
    req.route = {wr_data[F_RNS], wr_data[F_RSEC]};
    req.soff  = wr_data[F_SOFF];
  end

  assign grp_busy = groups_busy(ctl_q.soff, ctl_q.grp);

  irq_route_legal #(.N(N_ROUTE)) u_legal (
    .cur  (ctl_q.route),
    .req  (req.route),
    .busy (grp_busy),
    .nxt  (route_nxt),
    .bad  (route_bad)
  );

  irq_route_commit #(.COMMIT_CYC(COMMIT_CYC)) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wr_en),
    .pending (pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_en & (|route_bad);
      if (wr_en) begin
        ctl_q.grp   <= req.grp;
        ctl_q.soff  <= req.soff;
        ctl_q.route <= route_nxt;
      end
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[F_G0]   = ctl_q.grp[0];
    rd_data[F_G1A]  = ctl_q.grp[1];
    rd_data[F_G1B]  = ctl_q.grp[2];
    rd_data[F_RSEC] = ctl_q.route[0];
    rd_data[F_RNS]  = ctl_q.route[1];
    rd_data[F_SOFF] = ctl_q.soff;
    rd_data[F_PEND] = pending;
  end

  assign err_o = err_q;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              err_o,
  input logic              grp_busy,
  input logic [1:0]        route_bad
);
  localparam logic [DATA_W-1:0] USED = DATA_W'((1 << F_G0) | (1 << F_G1A) | (1 << F_G1B) |
                                       (1 << F_RSEC) | (1 << F_RNS) | (1 << F_SOFF)) |
                                       (DATA_W'(1) << F_PEND);

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~USED) == '0);  // R1
  AST_RSEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[F_RSEC] |=> rd_data[F_RSEC]);  // R2
  AST_RNS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[F_RNS] |=> rd_data[F_RNS]);  // R2
  AST_RSEC_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[F_RSEC]) |-> !$past(grp_busy));  // R3
  AST_RNS_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[F_RNS]) |-> !$past(grp_busy));  // R3
  AST_BAD_GIVES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|route_bad)) |=> err_o);  // R6
  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(wr_en));  // R6
  AST_PEND_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[F_PEND]);  // R7
  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[F_PEND]) |-> $past(wr_en));  // R7
  AST_GRP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[F_G0] == $past(wr_data[F_G0]));  // R6
endmodule

bind irq_route_ctrl irq_route_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .err_o     (err_o),
  .grp_busy  (grp_busy),
  .route_bad (route_bad)
);

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
  localparam int CYC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_route_ctrl #(.DATA_W(32), .COMMIT_CYC(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .err_o(err_o)
  );

  function automatic logic [31:0] word(input bit soff, input bit [1:0] rt, input bit [2:0] g);
    logic [31:0] w = '0;
    w[0] = g[0]; w[1] = g[1]; w[2] = g[2];
    w[4] = rt[0]; w[5] = rt[1]; w[6] = soff;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic poll_pending(output int n);
    n = 0;
    while (rd_data[31] && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    do_reset();
    check("R1 reset word", rd_data, 32'h0);
    check("R1 reset err", {31'b0, err_o}, 32'h0);

    do_write(32'hFFFF_FFFF);
    check("R1 layout unused bits", rd_data, 32'h8000_0077);
    check("R8 set from idle err", {31'b0, err_o}, 32'h0);

    do_reset();
    do_write(word(0, 2'b00, 3'b000));
    poll_pending(n);
    check("R7 pending length", n, CYC);
    do_write(word(0, 2'b00, 3'b001));
    @(negedge clk); @(negedge clk);
    do_write(word(0, 2'b00, 3'b011));
    poll_pending(n);
    check("R7 restart length", n, CYC);

    for (int s = 0; s < 2; s++)
      for (int g = 0; g < 8; g++)
        for (int c = 0; c < 4; c++)
          for (int r = 0; r < 4; r++) begin
            bit busy, e;
            bit [1:0] exp_rt;
            do_reset();
            do_write(word(s[0], c[1:0], 3'b000));
            check("R8 setup route", rd_data & 32'h7F, word(s[0], c[1:0], 3'b000));
            do_write(word(s[0], c[1:0], g[2:0]));
            check("R8 same-value rewrite err", {31'b0, err_o}, 32'h0);
            busy = s[0] ? (g[0] | g[1]) : (g[0] | g[1] | g[2]);  // R4 / R5
            e = 1'b0;
            for (int i = 0; i < 2; i++) begin
              bit ill;
              ill = (c[i] & ~r[i]) | (~c[i] & r[i] & busy);  // R2 / R3
              exp_rt[i] = ill ? c[i] : r[i];
              e |= ill;
            end
            do_write(word(s[0], r[1:0], g[2:0]));
            check(s ? "R5 word after write" : "R4 word after write", rd_data,
                  32'h8000_0000 | word(s[0], exp_rt, g[2:0]));
            check("R6 err pulse", {31'b0, err_o}, {31'b0, e});
            @(negedge clk);
            check("R6 err one cycle", {31'b0, err_o}, 32'h0);
          end

    do_reset();
    do_write(word(0, 2'b11, 3'b000));
    do_write(word(1, 2'b00, 3'b111));
    check("R2 clear refused, R6 fields taken", rd_data & 32'h7F, word(1, 2'b11, 3'b111));
    check("R2 clear err", {31'b0, err_o}, 32'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule